// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block lets synchronous logic use an external asynchronous static RAM of 4096 words by 4 bits. The RAM has separate input and output data pins. A host hands over one read or one write at a time through a valid/ready handshake. The block then drives the address, the write data, the active-low chip select and the active-low write strobe. It holds each strobe for a whole number of clock cycles, worked out from the clock period and the RAM's timing figures. A read ends with a one-cycle response pulse that carries the sampled word.

The timing figures are parameters given in picoseconds. Each figure is rounded up to whole clock cycles, so moving to another clock or another speed grade only means changing the numbers.

A mode parameter describes the RAM variant:
- In the write-through variant, the RAM shows the incoming word on its outputs while a write is in progress. The block samples that echo at the end of the write and returns it as a response, so the host gets a confirmation of the write.
- In the variant whose outputs float during a write, nothing is sampled and a write gives no response.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, chip select and write strobe are high (inactive) and the response flag is low. While reset is applied, or while an operation is in flight, `req_ready` is low. `req_ready` is high only when the block is idle, and then chip select is high.
- R2: A read (`req_write`=0) holds chip select low with the write strobe high for the read hold count. `rsp_valid` is high for exactly one cycle, in the cycle right after chip select rises. `rsp_rdata` is the word the RAM presented at the end of the access. Counting the negative clock edges after the accepting clock edge, the response appears on edge read-hold-count + 2.
- R3: A write (`req_write`=1) pulls the write strobe low only while chip select is low, for the write hold count. Both strobes rise on the same clock edge.
- R4: The address and write data are driven one cycle before chip select falls, and they stay unchanged while chip select is low. Chip select is high for at least one cycle between two operations.
- R5: Each hold count is its timing figure divided by the clock period and rounded up, with a minimum of 1. The read count uses the access time. The write count is the largest of: the write pulse width, the data setup time, and (in write-through mode only) the echo time. At 4 ns clock and 12/12/7/12 ns figures, both counts are 3.
- R6: With `ECHO_ON_WRITE`=1, a write ends with a one-cycle response carrying the echoed word, at the same latency as a read. With `ECHO_ON_WRITE`=0, a write produces no response.
- R7: A request presented while `req_ready` is low is ignored: it starts no RAM cycle and does not change memory contents.
- R8: A read after a write to the same address returns the written word, in both modes, including at addresses 0x000 and 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 4 | Word to write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 4 | Word read from the RAM (or echoed on a write) |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_addr | output | 12 | RAM address |
| mem_din | output | 4 | RAM data input pins |
| mem_dout | input | 4 | RAM data output pins |

## Verification
The stimulus mixes writes and reads:
- the two ends of the address space, which catch a truncated or swapped address path;
- an overwrite of one location, which shows the data is really stored and not left over from an earlier write;
- complementary data patterns, which expose stuck or swapped data bits.

The behavioural RAM drives the inverted word until the access or echo time has elapsed, so a hold count that is one cycle short returns wrong data instead of passing silently. Two instances, one per output mode, receive identical traffic. This shows that only the write response differs between the modes.

A request pulsed during a busy write, followed by a read-back, shows that such requests are ignored.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2
  } seq_state_e;

  // Round a time in ps up to whole clock cycles, never less than one.
  function automatic int unsigned hold_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/sram_hold_timer.sv
module sram_hold_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = load | dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WR_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             tmr_dec,
  output logic             finish,
  output logic             op_write,
  output logic             cs_n_d,
  output logic             we_n_d
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

  seq_state_e state_q, state_d;
  logic       wr_q, wr_d;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          wr_d    = req_write;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        // address already on the pins for this whole cycle
        tmr_load = 1'b1;
        state_d  = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (tmr_zero) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_val   = wr_q ? WR_LOAD : RD_LOAD;
  assign cs_n_d    = (state_d != ST_ACTIVE);
  assign we_n_d    = !((state_d == ST_ACTIVE) && wr_d);
  assign req_ready = (state_q == ST_IDLE) && rst_n;
  assign op_write  = wr_q;

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) wr_q <= wr_d;
    end
  end

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs #(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 4,
  parameter bit          ECHO_ON_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cs_n_d,
  input  logic              we_n_d,
  input  logic              finish,
  input  logic              op_write,
  input  logic [DATA_W-1:0] mem_dout,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam bit SAMPLE_WR = ECHO_ON_WRITE;

  logic              cs_n_q, we_n_q, rsp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q, rdata_q;
  logic              take;

  // Sample the RAM outputs at the end of a read, and at the end of a write
  // only when the RAM echoes the written word.
  assign take = finish & (SAMPLE_WR | ~op_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      rsp_q   <= 1'b0;
      addr_q  <= '0;
      din_q   <= '0;
      rdata_q <= '0;
    end else begin
      cs_n_q <= cs_n_d;
      we_n_q <= we_n_d;
      rsp_q  <= take;
      if (accept) begin
        addr_q <= req_addr;
        din_q  <= req_wdata;
      end
      if (take) begin
        rdata_q <= mem_dout;
      end
    end
  end

  assign mem_cs_n  = cs_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_addr  = addr_q;
  assign mem_din   = din_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned CLK_PS        = 4000,
  parameter int unsigned T_RD_PS       = 12000,
  parameter int unsigned T_WP_PS       = 12000,
  parameter int unsigned T_DS_PS       = 7000,
  parameter int unsigned T_ECHO_PS     = 12000,
  parameter bit          ECHO_ON_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] mem_dout
);

  localparam int unsigned RD_CYC   = hold_cycles(T_RD_PS, CLK_PS);
  localparam int unsigned ECHO_CYC = ECHO_ON_WRITE ? hold_cycles(T_ECHO_PS, CLK_PS) : 1;
  localparam int unsigned WR_CYC   = max3(hold_cycles(T_WP_PS, CLK_PS),
                                          hold_cycles(T_DS_PS, CLK_PS), ECHO_CYC);
  localparam int unsigned MAX_CYC  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             rst_sync_n;
  logic             accept, tmr_load, tmr_dec, tmr_zero, finish, op_write;
  logic             cs_n_d, we_n_d;
  logic [CNT_W-1:0] tmr_val;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_seq_fsm #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_zero  (tmr_zero),
    .req_ready (req_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_dec   (tmr_dec),
    .finish    (finish),
    .op_write  (op_write),
    .cs_n_d    (cs_n_d),
    .we_n_d    (we_n_d)
  );

  sram_hold_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  sram_pin_regs #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .ECHO_ON_WRITE (ECHO_ON_WRITE)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cs_n_d    (cs_n_d),
    .we_n_d    (we_n_d),
    .finish    (finish),
    .op_write  (op_write),
    .mem_dout  (mem_dout),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_din   (mem_din),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned CLK_PS        = 4000,
  parameter int unsigned T_RD_PS       = 12000,
  parameter int unsigned T_WP_PS       = 12000,
  parameter int unsigned T_DS_PS       = 7000,
  parameter int unsigned T_ECHO_PS     = 12000,
  parameter bit          ECHO_ON_WRITE = 1'b0
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_din
);

  localparam int unsigned EXP_RD = hold_cycles(T_RD_PS, CLK_PS);
  localparam int unsigned EXP_WR = max3(hold_cycles(T_WP_PS, CLK_PS),
                                        hold_cycles(T_DS_PS, CLK_PS),
                                        ECHO_ON_WRITE ? hold_cycles(T_ECHO_PS, CLK_PS) : 1);

  // Length of the current low phase of chip select, and whether it wrote.
  logic [15:0] low_cnt;
  logic        low_wr;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      low_cnt <= '0;
      low_wr  <= 1'b0;
    end else begin
      low_cnt <= mem_cs_n ? 16'd0 : low_cnt + 16'd1;
      low_wr  <= mem_cs_n ? 1'b0 : ~mem_we_n;
    end
  end

  // R1: ready only while no RAM cycle is running
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    req_ready |-> mem_cs_n);

  // R2: response lasts one cycle
  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |=> !rsp_valid);

  // R2: response appears right after chip select rises
  a_r2_rsp_at_end: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |-> $rose(mem_cs_n));

  // R3: write strobe only inside chip select
  a_r3_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_ok)
    !mem_we_n |-> !mem_cs_n);

  // R3: both strobes rise together
  a_r3_rise_together: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(mem_we_n) |-> $rose(mem_cs_n));

  // R4: address and data settled before chip select falls
  a_r4_setup_before_cs: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(mem_cs_n) |-> ($stable(mem_addr) && $stable(mem_din)));

  // R4: address and data steady while chip select is low
  a_r4_hold_while_low: assert property (@(posedge clk) disable iff (!rst_ok)
    !mem_cs_n |=> (mem_cs_n || ($stable(mem_addr) && $stable(mem_din))));

  // R4: chip select high for at least one cycle between operations
  a_r4_cs_gap: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(mem_cs_n) |=> mem_cs_n);

  // R5: low phase length matches the rounded hold count
  a_r5_hold_len: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(mem_cs_n) |-> (low_cnt == (low_wr ? 16'(EXP_WR) : 16'(EXP_RD))));

  // R6: without the echo mode a write never responds
  a_r6_no_write_rsp: assert property (@(posedge clk) disable iff (!rst_ok)
    rsp_valid |-> (ECHO_ON_WRITE || $past(mem_we_n)));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .CLK_PS        (CLK_PS),
  .T_RD_PS       (T_RD_PS),
  .T_WP_PS       (T_WP_PS),
  .T_DS_PS       (T_DS_PS),
  .T_ECHO_PS     (T_ECHO_PS),
  .ECHO_ON_WRITE (ECHO_ON_WRITE)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_din   (mem_din)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps

// Behavioural RAM: data becomes correct only after the access (or echo) time;
// before that it shows the inverted word. Timing breaches are counted.
module sim_sram_model #(
  parameter int ACC_CYC  = 3,
  parameter int WP_CYC   = 3,
  parameter int ECHO_CYC = 3,
  parameter bit ECHO     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        we_n,
  input  logic [11:0] addr,
  input  logic [3:0]  din,
  output logic [3:0]  dout,
  output int          viol
);

  logic [3:0]  mem [4096];
  int          lowcnt;
  logic        p_cs, p_we;
  logic [11:0] p_addr;
  logic [3:0]  p_din;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= 0; p_cs <= 1'b1; p_we <= 1'b1;
      p_addr <= '0; p_din <= '0; viol <= 0;
    end else begin
      p_cs <= cs_n; p_we <= we_n; p_addr <= addr; p_din <= din;
      lowcnt <= cs_n ? 0 : lowcnt + 1;
      if (!cs_n && !p_cs && (addr != p_addr || din != p_din)) viol <= viol + 1;
      if (!we_n && cs_n) viol <= viol + 1;
      if (!p_cs && !p_we && (cs_n || we_n)) begin
        if (lowcnt < WP_CYC) viol <= viol + 1;
        mem[p_addr] <= p_din;
      end
    end
  end

  always @* begin
    if (!cs_n && we_n)
      dout = (lowcnt + 1 >= ACC_CYC) ? mem[addr] : ~mem[addr];
    else if (!cs_n && !we_n)
      dout = ECHO ? ((lowcnt + 1 >= ECHO_CYC) ? din : ~din) : 4'bz;
    else
      dout = 4'bz;
  end

endmodule

module sim_sram_seq_ctrl;

  localparam int CLKP    = 4000;
  localparam int ACC_C   = (12000 + CLKP - 1) / CLKP;
  localparam int WP_C    = (12000 + CLKP - 1) / CLKP;
  localparam int ECHO_C  = (12000 + CLKP - 1) / CLKP;
  localparam int PULSE   = ACC_C;          // 3: all counts agree at these figures
  localparam int LAT     = PULSE + 2;      // negedges after accept until response

  // {write, addr[11:0], data[3:0]}; for reads data is the expected word
  localparam logic [16:0] OPS [12] = '{
    {1'b1, 12'h000, 4'h5}, {1'b1, 12'hFFF, 4'hA}, {1'b1, 12'h123, 4'h3},
    {1'b0, 12'h000, 4'h5}, {1'b0, 12'hFFF, 4'hA}, {1'b0, 12'h123, 4'h3},
    {1'b1, 12'h123, 4'hC}, {1'b0, 12'h123, 4'hC}, {1'b1, 12'h800, 4'h0},
    {1'b0, 12'h800, 4'h0}, {1'b1, 12'h7FF, 4'hF}, {1'b0, 12'h7FF, 4'hF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [11:0] req_addr;
  logic [3:0]  req_wdata;

  logic        ready0, rsp0, cs_n0, we_n0;
  logic [3:0]  rdata0, din0, dout0;
  logic [11:0] addr0;
  logic        ready1, rsp1, cs_n1, we_n1;
  logic [3:0]  rdata1, din1, dout1;
  logic [11:0] addr1;
  int          viol0, viol1;

  int n_checks = 0;
  int n_err    = 0;

  always #2 clk = ~clk;

  sram_seq_ctrl #(.ECHO_ON_WRITE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready0),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp0), .rsp_rdata(rdata0), .mem_cs_n(cs_n0), .mem_we_n(we_n0),
    .mem_addr(addr0), .mem_din(din0), .mem_dout(dout0));

  sram_seq_ctrl #(.ECHO_ON_WRITE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready1),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp1), .rsp_rdata(rdata1), .mem_cs_n(cs_n1), .mem_we_n(we_n1),
    .mem_addr(addr1), .mem_din(din1), .mem_dout(dout1));

  sim_sram_model #(.ACC_CYC(ACC_C), .WP_CYC(WP_C), .ECHO_CYC(ECHO_C), .ECHO(1'b0)) m0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n0), .we_n(we_n0), .addr(addr0),
    .din(din0), .dout(dout0), .viol(viol0));

  sim_sram_model #(.ACC_CYC(ACC_C), .WP_CYC(WP_C), .ECHO_CYC(ECHO_C), .ECHO(1'b1)) m1 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n1), .we_n(we_n1), .addr(addr1),
    .din(din1), .dout(dout1), .viol(viol1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [11:0] a, input logic [3:0] d,
                       input bit intrude);
    int low_c;
    int we_c;
    low_c = 0;
    we_c  = 0;
    @(negedge clk);
    chk(ready0 && ready1, "R1 ready when idle", int'(ready0 & ready1), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    for (int cyc = 1; cyc <= LAT; cyc++) begin
      @(negedge clk);
      if (cyc == 1) req_valid = 1'b0;
      if (intrude && cyc == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = ~d;
      end
      if (intrude && cyc == 3) req_valid = 1'b0;
      if (!cs_n0) low_c++;
      if (!we_n0) we_c++;
      if (cyc == 1) begin
        chk(cs_n0 && addr0 == a, "R4 address ahead of chip select", int'(addr0), int'(a));
        if (wr) chk(din0 == d, "R4 write data ahead of chip select", int'(din0), int'(d));
        chk(!ready0, "R1 busy drops ready", int'(ready0), 0);
      end
      if (cyc < LAT) begin
        chk(!rsp0 && !rsp1, "R2 no early response", int'(rsp0 | rsp1), 0);
      end else begin
        chk(ready0 && ready1, "R1 ready back at end", int'(ready0 & ready1), 1);
        if (wr) begin
          chk(!rsp0, "R6 no write response in float mode", int'(rsp0), 0);
          chk(rsp1 && rdata1 == d, "R6 echo response", int'(rdata1), int'(d));
        end else begin
          chk(rsp0 && rdata0 == d, "R8 read data float mode", int'(rdata0), int'(d));
          chk(rsp1 && rdata1 == d, "R8 read data echo mode", int'(rdata1), int'(d));
        end
      end
    end
    chk(low_c == PULSE, "R5 chip select hold count", low_c, PULSE);
    chk(we_c == (wr ? PULSE : 0), "R3 write strobe length", we_c, wr ? PULSE : 0);
    @(negedge clk);
    chk(!rsp0 && !rsp1, "R2 response one cycle", int'(rsp0 | rsp1), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n0 && we_n0 && cs_n1 && we_n1, "R1 strobes idle in reset", int'(cs_n0 & we_n0), 1);
    chk(!rsp0 && !rsp1, "R1 no response in reset", int'(rsp0 | rsp1), 0);
    chk(!ready0 && !ready1, "R1 not ready in reset", int'(ready0 | ready1), 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // table walk
    for (int i = 0; i < 12; i++) begin
      do_op(OPS[i][16], OPS[i][15:4], OPS[i][3:0], 1'b0);
    end

    // R7: request during a busy write is ignored
    do_op(1'b1, 12'h055, 4'h9, 1'b1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(cs_n0 && cs_n1, "R7 no cycle from ignored request", int'(cs_n0 & cs_n1), 1);
    end
    do_op(1'b0, 12'h055, 4'h9, 1'b0);

    // R4: back-to-back read then write then read, then timing breaches
    do_op(1'b0, 12'hFFF, 4'hA, 1'b0);
    do_op(1'b1, 12'hFFF, 4'h6, 1'b0);
    do_op(1'b0, 12'hFFF, 4'h6, 1'b0);
    chk(viol0 == 0, "R4 RAM timing float mode", viol0, 0);
    chk(viol1 == 0, "R4 RAM timing echo mode", viol1, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule